// File: doc/BRIEF.md
# Ring Buffer Fetch Request Generator

This block decides when a memory fetch should be started to refill a small ring buffer that feeds a streaming device such as a display or disk channel. The ring holds sixteen entries and is filled from memory in groups of four words. A write pointer advances each time memory delivers a word into the ring, and a read pointer advances each time the device consumes one.

The block keeps both pointers and evaluates a sparse function of them. A fetch is requested only when both pointers rest exactly on a group boundary and the writer leads the reader by zero, one or two whole groups, which means a free group of four entries remains. Any partially transferred group, or a lead of three groups, suppresses the request. The request leaves the block as a registered, active-low signal, so it moves only on clock edges and reflects the pointer values produced by that same edge.

Pointer width, group size and the largest lead that still requests a fetch are parameters; the defaults give the sixteen-entry, four-word arrangement.

Top module: `mem_req_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, both pointers are 0 and `fetch_req_n` is 0 (request active).
- R2: Each cycle with `wr_stb` high advances the write pointer by one, wrapping from 15 to 0; without the strobe it holds.
- R3: Each cycle with `rd_stb` high advances the read pointer by one, wrapping from 15 to 0; without the strobe it holds.
- R4: `fetch_req_n` is 0 when both pointers are multiples of 4 and (write − read) mod 16 is 0, 4 or 8; for read pointer 0, 4, 8 and 12 this means write pointer {0,4,8}, {4,8,12}, {8,12,0} and {12,0,4} respectively.
- R5: `fetch_req_n` is 1 whenever either pointer is not a multiple of 4.
- R6: `fetch_req_n` is 1 when both pointers are aligned but the writer leads by 12 (three groups).
- R7: `fetch_req_n` is a register output: after a clock edge it already reflects the pointer values that edge produced, and it does not change between edges.
- R8: When `wr_stb` and `rd_stb` are high in the same cycle both pointers advance, so their difference is unchanged and the request follows the new aligned positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | A word was written into the ring this cycle |
| rd_stb | input | 1 | A word was consumed from the ring this cycle |
| fetch_req_n | output | 1 | Registered fetch request, active low |

## Verification
The two functions that can meet in one cycle are the write advance and the read advance. The bench raises both strobes together at aligned and misaligned positions, including around the 15-to-0 wrap, and judges the request against a model in which both pointers step at once, so the lead is preserved and only the new positions decide the output. A pseudo-random strobe run then mixes single and joint advances against the same model.

// File: rtl/mem_req_pkg.sv
package mem_req_pkg;
   // Default geometry: 16-entry ring, 4-word groups, up to 2 groups of lead requests a fetch.
   localparam int DEF_PTR_W    = 4;
   localparam int DEF_GROUP_W  = 2;
   localparam int DEF_MAX_LEAD = 2;

   // Number of whole groups in a ring of the given geometry.
   function automatic int group_count(input int ptr_w, input int group_w);
      return 1 << (ptr_w - group_w);
   endfunction
endpackage

// File: rtl/ring_ptr.sv
module ring_ptr #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   output logic [W-1:0] cnt,
   output logic [W-1:0] cnt_nxt
);
   generate
      if (W < 1) begin : g_bad_w
         $error("ring_ptr: W must be at least 1");
      end
   endgenerate

   always_comb begin
      cnt_nxt = cnt;
      if (adv) cnt_nxt = cnt + W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_nxt;
   end

   // Pointer steps by exactly one per strobe, wrapping naturally (R2 for writes, R3 for reads).
   assert_cnt_step_R2_R3: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> cnt == $past(cnt) + W'(1));

   assert_cnt_hold_R2_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(cnt));
endmodule

// File: rtl/mem_req_decode.sv
module mem_req_decode #(
   parameter int PTR_W    = 4,
   parameter int GROUP_W  = 2,
   parameter int MAX_LEAD = 2
) (
   input  logic [PTR_W-1:0] wr_ptr,
   input  logic [PTR_W-1:0] rd_ptr,
   output logic             req
);
   localparam int GW = PTR_W - GROUP_W;

   logic          aligned;
   logic [GW-1:0] lead;
   logic [MAX_LEAD:0] hit;

   assign aligned = (wr_ptr[GROUP_W-1:0] == '0) && (rd_ptr[GROUP_W-1:0] == '0);
   assign lead    = wr_ptr[PTR_W-1:GROUP_W] - rd_ptr[PTR_W-1:GROUP_W];

   // One comparator per permitted group lead.
   genvar g;
   generate
      for (g = 0; g <= MAX_LEAD; g++) begin : g_lead
         assign hit[g] = (lead == GW'(g));
      end
   endgenerate

   assign req = aligned && (|hit);
endmodule

// File: rtl/mem_req_gen.sv
module mem_req_gen #(
   parameter int PTR_W    = mem_req_pkg::DEF_PTR_W,
   parameter int GROUP_W  = mem_req_pkg::DEF_GROUP_W,
   parameter int MAX_LEAD = mem_req_pkg::DEF_MAX_LEAD
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_stb,
   input  logic rd_stb,
   output logic fetch_req_n
);
   localparam int GROUPS = mem_req_pkg::group_count(PTR_W, GROUP_W);
   localparam logic [PTR_W-1:0] LEAD_LIMIT = PTR_W'(MAX_LEAD);
   localparam logic [PTR_W-1:0] FULL_GAP   = PTR_W'((MAX_LEAD + 1) << GROUP_W);

   generate
      if (GROUP_W < 1 || GROUP_W >= PTR_W) begin : g_bad_group
         $error("mem_req_gen: GROUP_W must be in 1..PTR_W-1");
      end
      if (MAX_LEAD < 0 || MAX_LEAD + 1 >= GROUPS) begin : g_bad_lead
         $error("mem_req_gen: MAX_LEAD must leave at least one group free");
      end
   endgenerate

   logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
   logic             req_d;

   ring_ptr #(.W(PTR_W)) u_wr_ptr (
      .clk(clk), .rst_n(rst_n), .adv(wr_stb), .cnt(wr_q), .cnt_nxt(wr_d));

   ring_ptr #(.W(PTR_W)) u_rd_ptr (
      .clk(clk), .rst_n(rst_n), .adv(rd_stb), .cnt(rd_q), .cnt_nxt(rd_d));

   // Decode the pointer values being loaded, so the registered output lines up with them.
   mem_req_decode #(.PTR_W(PTR_W), .GROUP_W(GROUP_W), .MAX_LEAD(MAX_LEAD)) u_decode (
      .wr_ptr(wr_d), .rd_ptr(rd_d), .req(req_d));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fetch_req_n <= 1'b0;
      else        fetch_req_n <= ~req_d;
   end

   logic [PTR_W-1:0] ptr_gap;
   assign ptr_gap = wr_q - rd_q;

   assert_reset_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!fetch_req_n && wr_q == '0 && rd_q == '0));

   assert_lead_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_req_n |-> ((ptr_gap >> GROUP_W) <= LEAD_LIMIT));

   assert_misaligned_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_q[GROUP_W-1:0] != '0 || rd_q[GROUP_W-1:0] != '0) |-> fetch_req_n);

   assert_full_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_gap == FULL_GAP) |-> fetch_req_n);

   assert_joint_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && rd_stb) |=> $stable(ptr_gap));
endmodule

// File: tb/mem_req_gen_bench.sv
module mem_req_gen_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_stb = 1'b0;
   logic rd_stb = 1'b0;
   logic fetch_req_n;

   always #5 clk = ~clk;

   mem_req_gen u_mem_req_gen (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
      .fetch_req_n(fetch_req_n));

   int checks = 0;
   int bad = 0;
   bit done = 1'b0;

   logic exp_q[$];
   string tag_q[$];
   logic last_seen;
   bit   armed = 1'b0;

   int m_wr = 0;
   int m_rd = 0;

   function automatic logic model_req_n(input int w, input int r);
      int gap;
      gap = (w - r + 16) % 16;
      if ((w % 4) != 0 || (r % 4) != 0) return 1'b1;
      return !(gap == 0 || gap == 4 || gap == 8);
   endfunction

   function automatic string model_tag(input int w, input int r, input bit wrap_w,
                                       input bit wrap_r, input bit both);
      int gap;
      gap = (w - r + 16) % 16;
      if (both) return "R8";
      if (wrap_w) return "R2";
      if (wrap_r) return "R3";
      if ((w % 4) != 0 || (r % 4) != 0) return "R5";
      if (gap == 12) return "R6";
      return "R4";
   endfunction

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: fetch_req_n=%b expected %b (wr=%0d rd=%0d)", tag, act, exp, m_wr, m_rd);
      end
   endtask

   // Driver: apply strobes for one cycle and queue the expected registered output.
   task automatic step(input bit w, input bit r);
      bit wrap_w, wrap_r;
      @(negedge clk);
      wr_stb = w;
      rd_stb = r;
      wrap_w = w && (m_wr == 15);
      wrap_r = r && (m_rd == 15);
      if (w) m_wr = (m_wr + 1) % 16;
      if (r) m_rd = (m_rd + 1) % 16;
      exp_q.push_back(model_req_n(m_wr, m_rd));
      tag_q.push_back(model_tag(m_wr, m_rd, wrap_w, wrap_r, w && r));
   endtask

   // Monitor: compare shortly after each edge, then confirm no change before the next edge (R7).
   always @(posedge clk) begin
      #2;
      if (exp_q.size() > 0) begin
         check(tag_q.pop_front(), fetch_req_n, exp_q.pop_front());
         last_seen = fetch_req_n;
         armed = 1'b1;
      end
   end

   always @(negedge clk) begin
      if (armed) begin
         armed = 1'b0;
         check("R7", fetch_req_n, last_seen);
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         bad++;
         checks++;
         $display("FAIL watchdog: run did not complete (act=hung exp=done)");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] lfsr;
      repeat (3) @(negedge clk);
      check("R1", fetch_req_n, 1'b0);           // held in reset
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", fetch_req_n, 1'b0);           // first cycle after reset, pointers at 0

      // Fill: write pointer walks 1..16, crossing leads 1,2,3 groups and wrapping.
      for (int i = 0; i < 16; i++) step(1'b1, 1'b0);
      // Drain: reader walks all aligned positions with writer parked at 0.
      for (int i = 0; i < 16; i++) step(1'b0, 1'b1);
      // Set writer 8 ahead, then sweep reader round with writer following.
      for (int i = 0; i < 8; i++) step(1'b1, 1'b0);
      for (int i = 0; i < 20; i++) step(1'b1, 1'b1);   // joint advances across wrap
      for (int i = 0; i < 4; i++) step(1'b1, 1'b0);    // lead becomes 12, request off
      for (int i = 0; i < 6; i++) step(1'b1, 1'b1);
      for (int i = 0; i < 3; i++) step(1'b0, 1'b0);    // idle hold

      lfsr = 8'hA5;
      for (int i = 0; i < 400; i++) begin
         step(lfsr[0], lfsr[3]);
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      end
      step(1'b0, 1'b0);
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule